// File: doc/BRIEF.md
# Auxiliary Output Port Generator

This block drives five auxiliary pins of a display controller from a single system clock. One pin (the pump pin) can carry a clock for a DC-DC converter. Two phase pins can carry a pulse-width-modulated waveform for driving a filament. Two general pins can carry a buzzer clock at one of three rates. Each pin can also show a status flag from the rest of the chip (blink phase or shutdown), repeat the serial data-out bit, or hold a fixed logic level. The set of functions differs by pin.

Each pin has its own 3-bit configuration code, driven by a register block elsewhere. One shared set of counters produces every timing source. All clock outputs come from toggle flip-flops, so they have a 50 % duty cycle. Each pin's output is registered after its function selector, so a change of code or of a followed input shows at the pin one clock later. With the default parameters and a 4 MHz clock, the pump clock is 80 kHz, the filament PWM is 10 kHz, and the buzzer clocks are 2500, 1250 and 625 Hz.

Top module: `auxport_gen`

## Requirements
- R1: While `rstN` is low, all five outputs are low.
- R2: On every pin, code 3'b000 drives the output low and code 3'b001 drives it high, one clock after the code is applied.
- R3: Pump code 3'b010 gives a square wave with a period of `PUMP_DIV` clocks, high for `PUMP_DIV/2` of them.
- R4: Pump code 3'b011 and general-pin code 3'b101 copy `sdoIn` to the pin with one clock of delay.
- R5: Phase code 3'b010 gives a PWM with a period of `PWM_PERIOD` clocks, high for floor(`filDuty` × `PWM_PERIOD` / 256) clocks. A duty of 0 keeps the pin low.
- R6: In PWM mode, phase pin 2 carries the inverse of phase pin 1's PWM. When both phase pins are in PWM mode they are never equal.
- R7: Phase code 3'b011 and general-pin code 3'b110 copy `blinkPhase` to the pin with one clock of delay.
- R8: General-pin codes 3'b010, 3'b011 and 3'b100 give square waves with periods of `BUZ_DIV`, 2×`BUZ_DIV` and 4×`BUZ_DIV` clocks, each with 50 % duty.
- R9: General-pin code 3'b111 copies `shutdown` to the pin with one clock of delay.
- R10: On the pump and phase pins, codes 3'b100 to 3'b111 drive the output low.
- R11: Two general pins set to the same code carry identical waveforms, because all pins share one divider chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pumpCfg | input | 3 | Function code for the pump pin |
| phase1Cfg | input | 3 | Function code for phase pin 1 |
| phase2Cfg | input | 3 | Function code for phase pin 2 |
| port0Cfg | input | 3 | Function code for general pin 0 |
| port1Cfg | input | 3 | Function code for general pin 1 |
| filDuty | input | 8 | Filament PWM duty, in 1/256 steps |
| blinkPhase | input | 1 | Current blink phase |
| shutdown | input | 1 | Shutdown status flag |
| sdoIn | input | 1 | Serial data-out bit |
| pumpOut | output | 1 | Pump pin |
| phase1Out | output | 1 | Phase pin 1 |
| phase2Out | output | 1 | Phase pin 2 |
| port0Out | output | 1 | General pin 0 |
| port1Out | output | 1 | General pin 1 |

## Verification
The bench builds the block with `PUMP_DIV` = 10, `PWM_PERIOD` = 20 and `BUZ_DIV` = 8. These values make every waveform period a few dozen clocks at most, so whole high and low phases are counted edge to edge for each clock rate and each duty value. A period of 20 makes the flooring visible: a duty of 255 gives 19 high clocks, not 20, and a duty of 0 gives a pin that never rises. The short buzzer base also lets the bench compare two general pins at the same rate over several full periods.

// File: rtl/auxport_pkg.sv
package auxport_pkg;

  localparam int NUM_RATES = 3;

  // codes shared by every pin
  localparam logic [2:0] CFG_LOW  = 3'b000;
  localparam logic [2:0] CFG_HIGH = 3'b001;

  // pump pin
  localparam logic [2:0] PUMP_CLK = 3'b010;
  localparam logic [2:0] PUMP_SDO = 3'b011;

  // phase pins
  localparam logic [2:0] PH_PWM   = 3'b010;
  localparam logic [2:0] PH_BLINK = 3'b011;

  // general pins
  localparam logic [2:0] PT_CLK_FAST = 3'b010;
  localparam logic [2:0] PT_CLK_MID  = 3'b011;
  localparam logic [2:0] PT_CLK_SLOW = 3'b100;
  localparam logic [2:0] PT_SDO      = 3'b101;
  localparam logic [2:0] PT_BLINK    = 3'b110;
  localparam logic [2:0] PT_SHDN     = 3'b111;

  // strobes from the timebase to the output datapath
  typedef struct packed {
    logic                 pumpTgl;
    logic [NUM_RATES-1:0] buzTgl;
    logic                 pwmOn;
  } tickBus_t;

endpackage

// File: rtl/auxport_timebase.sv
module auxport_timebase
  import auxport_pkg::*;
#(
  parameter int PUMP_DIV   = 50,
  parameter int PWM_PERIOD = 400,
  parameter int BUZ_DIV    = 1600
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] filDuty,
  output tickBus_t   tick
);

  localparam int PUMP_HALF = PUMP_DIV / 2;
  localparam int BUZ_HALF  = BUZ_DIV / 2;
  localparam int PUMP_W    = $clog2(PUMP_HALF + 1);
  localparam int BUZ_W     = $clog2(BUZ_HALF + 1);
  localparam int PWM_W     = $clog2(PWM_PERIOD + 1);
  localparam int PROD_W    = PWM_W + 9;
  localparam int HIGH_W    = PROD_W - 8;
  localparam int CHAIN_W   = NUM_RATES - 1;

  logic [PUMP_W-1:0]  pumpCnt;
  logic [BUZ_W-1:0]   buzCnt;
  logic [CHAIN_W-1:0] chainCnt;
  logic [PWM_W-1:0]   pwmCnt;
  logic               pumpTerm, buzTerm, pwmTerm;
  logic [NUM_RATES-1:0] buzTglVec;
  logic [PROD_W-1:0]  dutyProd;
  logic [HIGH_W-1:0]  highTime;

  assign pumpTerm = (pumpCnt == PUMP_W'(PUMP_HALF - 1));
  assign buzTerm  = (buzCnt == BUZ_W'(BUZ_HALF - 1));
  assign pwmTerm  = (pwmCnt == PWM_W'(PWM_PERIOD - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pumpCnt <= '0;
    end else if (pumpTerm) begin
      pumpCnt <= '0;
    end else begin
      pumpCnt <= pumpCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      buzCnt   <= '0;
      chainCnt <= '0;
    end else if (buzTerm) begin
      buzCnt   <= '0;
      chainCnt <= chainCnt + 1'b1;
    end else begin
      buzCnt <= buzCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmCnt <= '0;
    end else if (pwmTerm) begin
      pwmCnt <= '0;
    end else begin
      pwmCnt <= pwmCnt + 1'b1;
    end
  end

  // each slower rate toggles when all lower chain bits are set
  for (genvar k = 0; k < NUM_RATES; k++) begin : g_rate
    if (k == 0) begin : g_base
      assign buzTglVec[k] = buzTerm;
    end else begin : g_chain
      assign buzTglVec[k] = buzTerm & (&chainCnt[k-1:0]);
    end
  end

  assign dutyProd = PROD_W'(filDuty) * PROD_W'(PWM_PERIOD);
  assign highTime = dutyProd[PROD_W-1:8];

  always_comb begin
    tick.pumpTgl = pumpTerm;
    tick.buzTgl  = buzTglVec;
    tick.pwmOn   = (HIGH_W'(pwmCnt) < highTime);
  end

endmodule

// File: rtl/auxport_outmux.sv
module auxport_outmux
  import auxport_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  tickBus_t       tick,
  input  logic [2:0]     pumpCfg,
  input  logic [1:0][2:0] phaseCfg,
  input  logic [1:0][2:0] portCfg,
  input  logic           blinkPhase,
  input  logic           shutdown,
  input  logic           sdoIn,
  output logic           pumpOut,
  output logic [1:0]     phaseOut,
  output logic [1:0]     portOut
);

  logic                 pumpClk;
  logic [NUM_RATES-1:0] buzClk;
  logic                 pumpNext;
  logic [1:0]           phaseNext;
  logic [1:0]           portNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pumpClk <= 1'b0;
    end else if (tick.pumpTgl) begin
      pumpClk <= ~pumpClk;
    end
  end

  for (genvar k = 0; k < NUM_RATES; k++) begin : g_buzClk
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        buzClk[k] <= 1'b0;
      end else if (tick.buzTgl[k]) begin
        buzClk[k] <= ~buzClk[k];
      end
    end
  end

  always_comb begin
    unique case (pumpCfg)
      CFG_HIGH: pumpNext = 1'b1;
      PUMP_CLK: pumpNext = pumpClk;
      PUMP_SDO: pumpNext = sdoIn;
      default:  pumpNext = 1'b0;
    endcase
  end

  for (genvar p = 0; p < 2; p++) begin : g_phase
    // phase pin 2 carries the complement for differential drive
    logic pwmSrc;
    assign pwmSrc = (p == 0) ? tick.pwmOn : ~tick.pwmOn;
    always_comb begin
      unique case (phaseCfg[p])
        CFG_HIGH: phaseNext[p] = 1'b1;
        PH_PWM:   phaseNext[p] = pwmSrc;
        PH_BLINK: phaseNext[p] = blinkPhase;
        default:  phaseNext[p] = 1'b0;
      endcase
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    always_comb begin
      unique case (portCfg[p])
        CFG_HIGH:    portNext[p] = 1'b1;
        PT_CLK_FAST: portNext[p] = buzClk[0];
        PT_CLK_MID:  portNext[p] = buzClk[1];
        PT_CLK_SLOW: portNext[p] = buzClk[2];
        PT_SDO:      portNext[p] = sdoIn;
        PT_BLINK:    portNext[p] = blinkPhase;
        PT_SHDN:     portNext[p] = shutdown;
        default:     portNext[p] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pumpOut  <= 1'b0;
      phaseOut <= '0;
      portOut  <= '0;
    end else begin
      pumpOut  <= pumpNext;
      phaseOut <= phaseNext;
      portOut  <= portNext;
    end
  end

endmodule

// File: rtl/auxport_gen.sv
module auxport_gen
  import auxport_pkg::*;
#(
  parameter int PUMP_DIV   = 50,
  parameter int PWM_PERIOD = 400,
  parameter int BUZ_DIV    = 1600
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] pumpCfg,
  input  logic [2:0] phase1Cfg,
  input  logic [2:0] phase2Cfg,
  input  logic [2:0] port0Cfg,
  input  logic [2:0] port1Cfg,
  input  logic [7:0] filDuty,
  input  logic       blinkPhase,
  input  logic       shutdown,
  input  logic       sdoIn,
  output logic       pumpOut,
  output logic       phase1Out,
  output logic       phase2Out,
  output logic       port0Out,
  output logic       port1Out
);

  tickBus_t   tick;
  logic [1:0] phaseOut;
  logic [1:0] portOut;

  auxport_timebase #(
    .PUMP_DIV  (PUMP_DIV),
    .PWM_PERIOD(PWM_PERIOD),
    .BUZ_DIV   (BUZ_DIV)
  ) timebase_i (
    .clk    (clk),
    .rstN   (rstN),
    .filDuty(filDuty),
    .tick   (tick)
  );

  auxport_outmux outmux_i (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .pumpCfg   (pumpCfg),
    .phaseCfg  ({phase2Cfg, phase1Cfg}),
    .portCfg   ({port1Cfg, port0Cfg}),
    .blinkPhase(blinkPhase),
    .shutdown  (shutdown),
    .sdoIn     (sdoIn),
    .pumpOut   (pumpOut),
    .phaseOut  (phaseOut),
    .portOut   (portOut)
  );

  assign phase1Out = phaseOut[0];
  assign phase2Out = phaseOut[1];
  assign port0Out  = portOut[0];
  assign port1Out  = portOut[1];

endmodule

// File: rtl/auxport_gen_chk.sv
module auxport_gen_chk
  import auxport_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [2:0] pumpCfg,
  input logic [2:0] phase1Cfg,
  input logic [2:0] phase2Cfg,
  input logic [2:0] port0Cfg,
  input logic [2:0] port1Cfg,
  input logic [7:0] filDuty,
  input logic       blinkPhase,
  input logic       shutdown,
  input logic       sdoIn,
  input logic       pumpOut,
  input logic       phase1Out,
  input logic       phase2Out,
  input logic       port0Out,
  input logic       port1Out
);

  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  p_static_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pumpCfg == CFG_LOW) |=> !pumpOut);

  p_static_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    (port1Cfg == CFG_HIGH) |=> port1Out);

  p_serial_copy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (port0Cfg == PT_SDO) |=> (port0Out == $past(sdoIn)));

  p_diff_drive_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(phase1Cfg == PH_PWM && phase2Cfg == PH_PWM))
      |-> (phase1Out != phase2Out));

  p_blink_copy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (phase1Cfg == PH_BLINK) |=> (phase1Out == $past(blinkPhase)));

  p_shdn_copy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (port1Cfg == PT_SHDN) |=> (port1Out == $past(shutdown)));

  p_unused_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    pumpCfg[2] |=> !pumpOut);

  p_shared_chain_r11: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(port0Cfg == port1Cfg)) |-> (port0Out == port1Out));

endmodule

bind auxport_gen auxport_gen_chk chk_i (.*);

// File: tb/auxport_gen_tb_top.sv
module auxport_gen_tb_top;

  localparam int PUMP_DIV   = 10;
  localparam int PWM_PERIOD = 20;
  localparam int BUZ_DIV    = 8;
  localparam int GUARD      = 2000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] pumpCfg = 3'b000, phase1Cfg = 3'b000, phase2Cfg = 3'b000;
  logic [2:0] port0Cfg = 3'b000, port1Cfg = 3'b000;
  logic [7:0] filDuty = 8'd0;
  logic       blinkPhase = 1'b0, shutdown = 1'b0, sdoIn = 1'b0;
  logic       pumpOut, phase1Out, phase2Out, port0Out, port1Out;
  logic [4:0] outs;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  assign outs = {port1Out, port0Out, phase2Out, phase1Out, pumpOut};

  auxport_gen #(
    .PUMP_DIV  (PUMP_DIV),
    .PWM_PERIOD(PWM_PERIOD),
    .BUZ_DIV   (BUZ_DIV)
  ) dut_i (
    .clk(clk), .rstN(rstN),
    .pumpCfg(pumpCfg), .phase1Cfg(phase1Cfg), .phase2Cfg(phase2Cfg),
    .port0Cfg(port0Cfg), .port1Cfg(port1Cfg), .filDuty(filDuty),
    .blinkPhase(blinkPhase), .shutdown(shutdown), .sdoIn(sdoIn),
    .pumpOut(pumpOut), .phase1Out(phase1Out), .phase2Out(phase2Out),
    .port0Out(port0Out), .port1Out(port1Out)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // counts one whole wave of pin idx starting at a rising edge
  task automatic measure(input int idx, output int hi, output int per);
    int guard = 0;
    hi = 0;
    per = 0;
    while (outs[idx] == 1'b1 && guard < GUARD) begin @(negedge clk); guard++; end
    while (outs[idx] == 1'b0 && guard < GUARD) begin @(negedge clk); guard++; end
    while (outs[idx] == 1'b1 && guard < GUARD) begin hi++; per++; @(negedge clk); guard++; end
    while (outs[idx] == 1'b0 && guard < GUARD) begin per++; @(negedge clk); guard++; end
    if (guard >= GUARD) begin
      hi = -1;
      per = -1;
    end
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check("R1 outputs in reset", int'(outs), 0);
    rstN = 1'b1;
    settle();
    check("R1 outputs low after release", int'(outs), 0);
  endtask

  task automatic t_static();
    {pumpCfg, phase1Cfg, phase2Cfg, port0Cfg, port1Cfg} = {5{3'b001}};
    @(negedge clk);
    check("R2 static high all pins", int'(outs), 5'b11111);
    {pumpCfg, phase1Cfg, phase2Cfg, port0Cfg, port1Cfg} = '0;
    @(negedge clk);
    check("R2 static low all pins", int'(outs), 0);
  endtask

  task automatic t_unused();
    int seenHigh = 0;
    for (int c = 4; c < 8; c++) begin
      pumpCfg = 3'(c);
      phase1Cfg = 3'(c);
      phase2Cfg = 3'(c);
      repeat (12) begin
        @(negedge clk);
        if (pumpOut | phase1Out | phase2Out) seenHigh++;
      end
    end
    check("R10 unused codes stay low", seenHigh, 0);
    pumpCfg = 3'b000; phase1Cfg = 3'b000; phase2Cfg = 3'b000;
  endtask

  task automatic t_pump_clk();
    int hi, per;
    pumpCfg = 3'b010;
    settle();
    measure(0, hi, per);
    check("R3 pump period", per, PUMP_DIV);
    check("R3 pump high time", hi, PUMP_DIV / 2);
    pumpCfg = 3'b000;
  endtask

  task automatic t_serial();
    logic [9:0] pat = 10'b1101001110;
    int bad = 0;
    pumpCfg = 3'b011; port0Cfg = 3'b101; port1Cfg = 3'b101;
    for (int i = 0; i < 10; i++) begin
      sdoIn = pat[i];
      @(negedge clk);
      if (pumpOut != pat[i] || port0Out != pat[i] || port1Out != pat[i]) bad++;
    end
    check("R4 serial copy mismatches", bad, 0);
    sdoIn = 1'b1;
    @(negedge clk);
    check("R4 port1 follows sdo", int'(port1Out), 1);
    pumpCfg = 3'b000; port0Cfg = 3'b000; port1Cfg = 3'b000; sdoIn = 1'b0;
  endtask

  task automatic t_pwm_one(input int duty);
    int hi, per;
    int expHi = (duty * PWM_PERIOD) / 256;
    filDuty = 8'(duty);
    settle();
    measure(1, hi, per);
    check($sformatf("R5 pwm period duty %0d", duty), per, PWM_PERIOD);
    check($sformatf("R5 pwm high duty %0d", duty), hi, expHi);
  endtask

  task automatic t_pwm();
    int highs = 0;
    phase1Cfg = 3'b010;
    t_pwm_one(128);
    t_pwm_one(64);
    t_pwm_one(255);
    filDuty = 8'd0;
    settle();
    repeat (2 * PWM_PERIOD) begin
      @(negedge clk);
      if (phase1Out) highs++;
    end
    check("R5 duty zero stays low", highs, 0);
  endtask

  task automatic t_diff();
    int hi, per;
    int same = 0;
    phase1Cfg = 3'b010; phase2Cfg = 3'b010; filDuty = 8'd64;
    settle();
    measure(2, hi, per);
    check("R6 phase2 period", per, PWM_PERIOD);
    check("R6 phase2 high is complement", hi, PWM_PERIOD - (64 * PWM_PERIOD) / 256);
    repeat (2 * PWM_PERIOD) begin
      @(negedge clk);
      if (phase1Out == phase2Out) same++;
    end
    check("R6 phase pins never equal", same, 0);
    phase1Cfg = 3'b000; phase2Cfg = 3'b000;
  endtask

  task automatic t_blink();
    logic [7:0] pat = 8'b10110010;
    int bad = 0;
    phase1Cfg = 3'b011; phase2Cfg = 3'b011; port0Cfg = 3'b110;
    for (int i = 0; i < 8; i++) begin
      blinkPhase = pat[i];
      @(negedge clk);
      if (phase1Out != pat[i] || phase2Out != pat[i] || port0Out != pat[i]) bad++;
    end
    check("R7 blink copy mismatches", bad, 0);
    phase1Cfg = 3'b000; phase2Cfg = 3'b000; port0Cfg = 3'b000; blinkPhase = 1'b0;
  endtask

  task automatic t_port_clk();
    int hi, per;
    port0Cfg = 3'b010;
    settle();
    measure(3, hi, per);
    check("R8 fast rate period", per, BUZ_DIV);
    check("R8 fast rate high", hi, BUZ_DIV / 2);
    port0Cfg = 3'b011;
    settle();
    measure(3, hi, per);
    check("R8 mid rate period", per, 2 * BUZ_DIV);
    check("R8 mid rate high", hi, BUZ_DIV);
    port1Cfg = 3'b100;
    settle();
    measure(4, hi, per);
    check("R8 slow rate period", per, 4 * BUZ_DIV);
    check("R8 slow rate high", hi, 2 * BUZ_DIV);
    port0Cfg = 3'b000; port1Cfg = 3'b000;
  endtask

  task automatic t_shutdown();
    logic [5:0] pat = 6'b011010;
    int bad = 0;
    port1Cfg = 3'b111;
    for (int i = 0; i < 6; i++) begin
      shutdown = pat[i];
      @(negedge clk);
      if (port1Out != pat[i]) bad++;
    end
    check("R9 shutdown copy mismatches", bad, 0);
    port1Cfg = 3'b000; shutdown = 1'b0;
  endtask

  task automatic t_shared();
    int diff = 0;
    int rises = 0;
    logic prev;
    port0Cfg = 3'b011; port1Cfg = 3'b011;
    @(negedge clk);
    prev = port0Out;
    repeat (8 * BUZ_DIV) begin
      @(negedge clk);
      if (port0Out != port1Out) diff++;
      if (!prev && port0Out) rises++;
      prev = port0Out;
    end
    check("R11 same code same wave", diff, 0);
    check("R11 wave is toggling", int'(rises >= 2), 1);
    port0Cfg = 3'b000; port1Cfg = 3'b000;
  endtask

  initial begin
    t_reset();
    t_static();
    t_unused();
    t_pump_clk();
    t_serial();
    t_pwm();
    t_diff();
    t_blink();
    t_port_clk();
    t_shutdown();
    t_shared();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(10 * 100000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule